// File: doc/BRIEF.md
# Scaler Request Validator and Allocator

This block decides whether a single scaling request can be granted. It also keeps a registered bitmask that records which users currently hold a scaler. A request carries:

- the source and destination sizes,
- a generation select,
- format and mode flags,
- a user index,
- the scaler id that user currently holds (all ones, i.e. -1, when it holds none).

One clock after the request strobe, the block returns three things: accept or error, the id the user should keep, and the updated mask.

The checks run in a fixed order, and the order matters.

1. The block first works out whether a scaler is really needed. Any size change forces the need, whatever the need flag says.
2. A needed scaler in interlaced mode is rejected before anything else is looked at.
3. A request that no longer needs a scaler, or that asks to detach, releases the held scaler and succeeds.
4. Otherwise the four dimensions are tested against their limits. The maximum limits depend on the generation, and planar YUV sources carry a larger minimum. The user's bit is set only when all these tests pass.

Picking a concrete scaler id and programming the scaler itself are left to other logic.

Top module: `scl_req_check`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and is low otherwise. When `rsp_valid` is high, exactly one of `rsp_ok` and `rsp_err` is high. When `rsp_valid` is low, both are low.
- R2: A scaler counts as needed when `need_scaler_in` is high, or when `src_w != dst_w`, or when `src_h != dst_h`.
- R3: If a scaler is needed and `interlaced` is high, the response is an error. This applies even when `force_detach` is high.
- R4: When `force_detach` is high or no scaler is needed (and R3 does not apply), the response is ok and `id_out` is all ones. The bit for `user_idx` is cleared only if `id_in` was non-negative, that is, its top bit is 0.
- R5: When `yuv_semi` is high, a source width or source height below 16 is an error.
- R6: Any of the four dimensions below 8 is an error.
- R7: The maximum sizes depend on `gen_sel`:

  | `gen_sel` | src_w | src_h | dst_w | dst_h |
  |---|---|---|---|---|
  | 0 | 4096 | 4096 | 4096 | 4096 |
  | 1 | 5120 | 4096 | 5120 | 4096 |
  | 2 or 3 | 4096 | 8192 | 8192 | 8192 |

  Any dimension above its maximum is an error.
- R8: A needed, in-range request is ok. It sets bit `user_idx` of `user_mask`, and `id_out` equals `id_in`.
- R9: On an error, `user_mask` is unchanged and `id_out` equals `id_in`.
- R10: After reset, `user_mask` is 0 and `rsp_valid` is 0. The mask changes only in cycles where a response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| src_w | input | 14 | Source width |
| src_h | input | 14 | Source height |
| dst_w | input | 14 | Destination width |
| dst_h | input | 14 | Destination height |
| gen_sel | input | 2 | Generation: 0 oldest, 1 middle, 2 newest, 3 treated as newest |
| yuv_semi | input | 1 | Source is semiplanar YUV |
| interlaced | input | 1 | Interlaced mode active |
| need_scaler_in | input | 1 | Caller already requires a scaler |
| force_detach | input | 1 | Release any held scaler |
| user_idx | input | 3 | User index 0..7 |
| id_in | input | 4 | Held scaler id, two's complement, all ones means none |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Request accepted |
| rsp_err | output | 1 | Request rejected |
| id_out | output | 4 | Scaler id the user keeps |
| user_mask | output | 8 | Users currently holding a scaler |

## Verification
The hardest case to reach is the interaction between the ordering rules. In particular, an interlaced request that also asks to detach must be rejected instead of releasing, while an interlaced request with equal sizes must still release. The bench first places a user's bit in the mask through an accepted request. It then sends these conflicting flag mixes for the same user and watches whether the bit survives. Limit edges are hit at exact values on both sides for each generation code, including the reserved code.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int DIM_W  = 14;
  localparam int N_DIM  = 4;   // 0 src_w, 1 src_h, 2 dst_w, 3 dst_h
  localparam int MIN_ANY = 8;
  localparam int MIN_YUV = 16;

  typedef logic [DIM_W-1:0] dim_t;
  typedef dim_t [N_DIM-1:0] dims_t;

  typedef enum logic [1:0] {
    GEN_OLD = 2'd0,
    GEN_MID = 2'd1,
    GEN_NEW = 2'd2,
    GEN_RSV = 2'd3
  } gen_e;
endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 2'b00;
    else        q <= {q[0], 1'b1};
  end
  assign rst_ns = q[1];
endmodule

// File: rtl/scl_limits.sv
module scl_limits
  import scl_pkg::*;
(
  input  gen_e  gen,
  output dims_t max_lim
);
  always_comb begin
    unique case (gen)
      GEN_OLD: begin
        max_lim[0] = dim_t'(4096); max_lim[1] = dim_t'(4096);
        max_lim[2] = dim_t'(4096); max_lim[3] = dim_t'(4096);
      end
      GEN_MID: begin
        max_lim[0] = dim_t'(5120); max_lim[1] = dim_t'(4096);
        max_lim[2] = dim_t'(5120); max_lim[3] = dim_t'(4096);
      end
      default: begin  // newest and the reserved code
        max_lim[0] = dim_t'(4096); max_lim[1] = dim_t'(8192);
        max_lim[2] = dim_t'(8192); max_lim[3] = dim_t'(8192);
      end
    endcase
  end
endmodule

// File: rtl/scl_range_chk.sv
module scl_range_chk
  import scl_pkg::*;
(
  input  dims_t dims,
  input  dims_t max_lim,
  input  logic  yuv_semi,
  output logic  size_err
);
  logic [N_DIM-1:0] bad;

  for (genvar i = 0; i < N_DIM; i++) begin : g_dim
    // Source dimensions (index 0,1) carry the larger planar-YUV minimum (R5)
    localparam bit IS_SRC = (i < 2);
    logic below_min;
    always_comb begin
      below_min = (dims[i] < dim_t'(MIN_ANY));                      // R6
      if (IS_SRC && yuv_semi && dims[i] < dim_t'(MIN_YUV))
        below_min = 1'b1;
    end
    assign bad[i] = below_min || (dims[i] > max_lim[i]);            // R7
  end

  assign size_err = |bad;
endmodule

// File: rtl/scl_decide.sv
module scl_decide
  import scl_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  dims_t           dims,
  input  logic            need_in,
  input  logic            interlaced,
  input  logic            force_detach,
  input  logic            size_err,
  input  logic [ID_W-1:0] id_in,
  output logic            ok,
  output logic            set_bit,
  output logic            clr_bit,
  output logic [ID_W-1:0] id_out
);
  logic need;
  logic held;

  // R2: size change forces the need
  assign need = need_in || (dims[0] != dims[2]) || (dims[1] != dims[3]);
  assign held = !id_in[ID_W-1];

  always_comb begin
    ok      = 1'b0;
    set_bit = 1'b0;
    clr_bit = 1'b0;
    id_out  = id_in;
    if (need && interlaced) begin
      ok = 1'b0;                          // R3
    end else if (force_detach || !need) begin
      ok      = 1'b1;                     // R4
      clr_bit = held;
      id_out  = '1;
    end else if (!size_err) begin
      ok      = 1'b1;                     // R8
      set_bit = 1'b1;
    end
  end
endmodule

// File: rtl/scl_req_check.sv
module scl_req_check
  import scl_pkg::*;
#(
  parameter  int USERS  = 8,
  parameter  int ID_W   = 4,
  localparam int UIDX_W = $clog2(USERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DIM_W-1:0]  src_w,
  input  logic [DIM_W-1:0]  src_h,
  input  logic [DIM_W-1:0]  dst_w,
  input  logic [DIM_W-1:0]  dst_h,
  input  logic [1:0]        gen_sel,
  input  logic              yuv_semi,
  input  logic              interlaced,
  input  logic              need_scaler_in,
  input  logic              force_detach,
  input  logic [UIDX_W-1:0] user_idx,
  input  logic [ID_W-1:0]   id_in,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_err,
  output logic [ID_W-1:0]   id_out,
  output logic [USERS-1:0]  user_mask
);
  logic            rst_ns;
  dims_t           dims;
  dims_t           max_lim;
  logic            size_err;
  logic            ok_c, set_c, clr_c;
  logic [ID_W-1:0] id_c;

  logic            valid_d, ok_d, err_d;
  logic [ID_W-1:0] id_d;
  logic [USERS-1:0] mask_d;

  assign dims = {dst_h, dst_w, src_h, src_w};

  scl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  scl_limits u_lim (.gen(gen_e'(gen_sel)), .max_lim(max_lim));

  scl_range_chk u_rng (
    .dims(dims), .max_lim(max_lim), .yuv_semi(yuv_semi), .size_err(size_err)
  );

  scl_decide #(.ID_W(ID_W)) u_dec (
    .dims(dims), .need_in(need_scaler_in), .interlaced(interlaced),
    .force_detach(force_detach), .size_err(size_err), .id_in(id_in),
    .ok(ok_c), .set_bit(set_c), .clr_bit(clr_c), .id_out(id_c)
  );

  // next state
  always_comb begin
    valid_d = req_valid;
    ok_d    = req_valid && ok_c;
    err_d   = req_valid && !ok_c;
    id_d    = id_out;
    mask_d  = user_mask;
    if (req_valid) begin
      id_d = id_c;
      if (set_c) mask_d[user_idx] = 1'b1;
      if (clr_c) mask_d[user_idx] = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      id_out    <= '1;
      user_mask <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_ok    <= ok_d;
      rsp_err   <= err_d;
      if (req_valid) id_out <= id_d;
      user_mask <= mask_d;
    end
  end

  // R1: response one cycle after strobe
  a_r1_rsp_timing: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid |=> rsp_valid);
  // R1: ok and err mutually exclusive, and only with a response
  a_r1_ok_err_excl: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid ? (rsp_ok != rsp_err) : (!rsp_ok && !rsp_err));
  // R9: an error leaves the mask untouched
  a_r9_err_keeps_mask: assert property (@(posedge clk) disable iff (!rst_ns)
    (rsp_valid && rsp_err) |-> (user_mask == $past(user_mask)));
  // R10: mask moves only with a response
  a_r10_mask_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    !rsp_valid |-> $stable(user_mask));
  // R8: accept with a held id leaves the user's bit set
  a_r8_accept_sets: assert property (@(posedge clk) disable iff (!rst_ns)
    (rsp_valid && rsp_ok && !id_out[ID_W-1]) |-> user_mask[$past(user_idx)]);
endmodule

// File: tb/scl_req_check_tb.sv
module scl_req_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic [1:0]  gen_sel = '0;
  logic        yuv_semi = 1'b0, interlaced = 1'b0, need_scaler_in = 1'b0, force_detach = 1'b0;
  logic [2:0]  user_idx = '0;
  logic [3:0]  id_in = 4'hF;
  logic        rsp_valid, rsp_ok, rsp_err;
  logic [3:0]  id_out;
  logic [7:0]  user_mask;

  int checks = 0;
  int failures = 0;
  logic [7:0] m = 8'h00;  // expected mask

  always #10 clk = ~clk;  // 50 MHz

  scl_req_check u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .gen_sel(gen_sel), .yuv_semi(yuv_semi), .interlaced(interlaced),
    .need_scaler_in(need_scaler_in), .force_detach(force_detach),
    .user_idx(user_idx), .id_in(id_in),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
    .id_out(id_out), .user_mask(user_mask)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic req(input string r, input int sw, input int sh, input int dw, input int dh,
                     input logic [1:0] g, input logic yv, input logic il, input logic nd,
                     input logic fd, input logic [2:0] u, input logic [3:0] id,
                     input logic eok, input logic [3:0] eid);
    @(negedge clk);
    src_w = 14'(sw); src_h = 14'(sh); dst_w = 14'(dw); dst_h = 14'(dh);
    gen_sel = g; yuv_semi = yv; interlaced = il; need_scaler_in = nd;
    force_detach = fd; user_idx = u; id_in = id; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({r, " R1 valid"}, 32'(rsp_valid), 32'd1);
    check({r, " ok"},  32'(rsp_ok), 32'(eok));
    check({r, " err"}, 32'(rsp_err), 32'(!eok));
    check({r, " id"},  32'(id_out), 32'(eid));
    check({r, " mask"}, 32'(user_mask), 32'(m));
    @(negedge clk);
    check({r, " R1 idle"}, 32'({rsp_valid, rsp_ok, rsp_err}), 32'd0);
    check({r, " R10 mask hold"}, 32'(user_mask), 32'(m));
  endtask

  task automatic t_reset;
    check("R10 reset mask", 32'(user_mask), 32'd0);
    check("R10 reset valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_accept_release;
    m = 8'h04; req("R2 R8 mismatch forces need", 100, 100, 200, 200, 0, 0, 0, 0, 0, 2, 4'd1, 1, 4'd1);
    m = 8'h00; req("R4 no need releases", 50, 50, 50, 50, 0, 0, 0, 0, 0, 2, 4'd1, 1, 4'hF);
    m = 8'h20; req("R8 need flag equal size", 64, 64, 64, 64, 0, 0, 0, 1, 0, 5, 4'd0, 1, 4'd0);
    req("R4 no id held keeps bit", 64, 64, 64, 64, 0, 0, 0, 0, 0, 5, 4'hF, 1, 4'hF);
    m = 8'h00; req("R4 force detach", 64, 64, 128, 32, 0, 0, 0, 1, 1, 5, 4'd0, 1, 4'hF);
  endtask

  task automatic t_interlace;
    m = 8'h08; req("R8 setup", 100, 100, 120, 90, 1, 0, 0, 0, 0, 3, 4'd2, 1, 4'd2);
    req("R3 interlace rejects detach", 100, 100, 120, 90, 1, 0, 1, 0, 1, 3, 4'd2, 0, 4'd2);
    req("R3 R9 interlace need flag", 100, 100, 100, 100, 1, 0, 1, 1, 0, 3, 4'd2, 0, 4'd2);
    m = 8'h00; req("R4 interlace no need releases", 100, 100, 100, 100, 1, 0, 1, 0, 0, 3, 4'd2, 1, 4'hF);
  endtask

  task automatic t_yuv_min;
    req("R5 R9 yuv src_w 15", 15, 32, 64, 64, 0, 1, 0, 0, 0, 1, 4'd3, 0, 4'd3);
    req("R5 yuv src_h 15", 32, 15, 64, 64, 0, 1, 0, 0, 0, 1, 4'd3, 0, 4'd3);
    m = 8'h02; req("R5 yuv 16 ok", 16, 16, 32, 32, 0, 1, 0, 0, 0, 1, 4'd3, 1, 4'd3);
    m = 8'h82; req("R6 non-yuv 8 ok", 8, 8, 16, 16, 0, 0, 0, 0, 0, 7, 4'd4, 1, 4'd4);
    req("R6 dst_w 7", 8, 8, 7, 16, 0, 0, 0, 0, 0, 6, 4'd5, 0, 4'd5);
    req("R6 src_h 7", 8, 7, 16, 16, 0, 0, 0, 0, 0, 6, 4'd5, 0, 4'd5);
    req("R6 dst_h 7", 9, 9, 9, 7, 0, 0, 0, 0, 0, 6, 4'd5, 0, 4'd5);
  endtask

  task automatic t_gen;
    req("R7 g0 src_w 4097", 4097, 100, 4000, 100, 0, 0, 0, 0, 0, 0, 4'd6, 0, 4'd6);
    m = 8'h83; req("R7 g0 4096 ok", 4096, 4096, 4000, 4000, 0, 0, 0, 0, 0, 0, 4'd6, 1, 4'd6);
    req("R7 g0 dst_h 4097", 100, 100, 100, 4097, 0, 0, 0, 0, 0, 4, 4'd6, 0, 4'd6);
    m = 8'h93; req("R7 g1 5120 ok", 5120, 4096, 5120, 4000, 1, 0, 0, 0, 0, 4, 4'd7, 1, 4'd7);
    req("R7 g1 src_w 5121", 5121, 100, 5000, 100, 1, 0, 0, 0, 0, 6, 4'd7, 0, 4'd7);
    req("R7 g1 src_h 4097", 100, 4097, 100, 100, 1, 0, 0, 0, 0, 6, 4'd7, 0, 4'd7);
    req("R7 g2 src_w 4097", 4097, 100, 8000, 100, 2, 0, 0, 0, 0, 6, 4'd1, 0, 4'd1);
    m = 8'hD3; req("R7 g2 8192 ok", 4096, 8192, 8192, 8191, 2, 0, 0, 0, 0, 6, 4'd1, 1, 4'd1);
    req("R7 g2 dst_w 8193", 100, 100, 8193, 100, 2, 0, 0, 0, 0, 5, 4'd2, 0, 4'd2);
    m = 8'hF3; req("R7 g3 as newest", 100, 8192, 8192, 100, 3, 0, 0, 0, 0, 5, 4'd2, 1, 4'd2);
    req("R7 g3 src_w 4097", 4097, 100, 100, 100, 3, 0, 0, 0, 0, 2, 4'd2, 0, 4'd2);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_accept_release();
    t_interlace();
    t_yuv_min();
    t_gen();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule